// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

A 32-bit general-purpose I/O block with a small register slave using a single-cycle cyc/stb/ack handshake. Software sets a direction bit for each pin. Output pins drive the value of an output-data register. Input pins are synchronised and can be read back.

The synchronised inputs feed an edge detector. Rising-edge and falling-edge detection are enabled by two separate per-bit registers. A detected edge sets a sticky status bit, which is cleared by writing ones to a dedicated clear register. The status bits that survive a per-bit mask are ORed into one GPIO interrupt. That interrupt keeps bit 15 of a 16-bit global interrupt register set. The global register has its own write-one-to-clear and its own mask, and the masked value drives a 16-bit interrupt line output.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: A request (cyc and stb high) is acknowledged with a one-cycle `bus_ack` in the following cycle, and read data is valid together with that ack. Word offsets: 0 direction, 1 output data, 2 input data, 3 rising enable, 4 falling enable, 5 interrupt mask, 6 status, 7 status clear, 8 global status, 9 global mask. The output-data register reads back what was written.
- R2: `pin_oe` equals the direction register. `pin_out` carries the output-data bit where direction is 1, and 0 where direction is 0.
- R3: The input-data register returns the pin levels after a two-stage synchroniser, within four clocks of a change. Bits outside the wired-pin mask (by default only bit 31) read as 0 and never set status.
- R4: With a rising-edge enable bit set, a low-to-high transition of that input sets its status bit. Bits whose enable is 0 stay clear.
- R5: With a falling-edge enable bit set, a high-to-low transition sets its status bit. A low pulse of pattern P on a steady-high baseline therefore leaves status equal to ~P over the wired bits.
- R6: A status bit stays set after its pin returns to its former level.
- R7: Writing to the clear register clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R8: If an edge on a bit is detected in the same cycle that a clear write targets that bit, the bit remains set.
- R9: Global status bit 15 is set whenever (status AND interrupt mask) is non-zero. With a zero mask it stays 0.
- R10: Writing a value with bit 15 set to the global status register clears bit 15 unless the masked GPIO interrupt is still active. `irq_line` equals global status AND global mask, so bits other than 15 are always 0.
- R11: After reset, every register, `pin_out`, `pin_oe` and `irq_line` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq_line | output | 16 | Masked global interrupt lines |

## Verification
The hardest case to reach is a status-clear write that lands in the exact cycle the edge detector fires on the same bit. The bench changes a pin on a falling clock edge and counts two rising edges through the synchroniser. It then issues the clear write so that the write is taken on the edge where the status register captures the new edge. The same write also clears an older status bit, so the outcome separates "edge wins" from "nothing cleared". A second hard case is re-asserting global bit 15 while the GPIO status is still pending. The bench clears the global bit without first clearing the status and expects the bit to read back as 1.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_DIR   = 4'd0,
    REG_DOUT  = 4'd1,
    REG_DIN   = 4'd2,
    REG_RISE  = 4'd3,
    REG_FALL  = 4'd4,
    REG_MASK  = 4'd5,
    REG_STAT  = 4'd6,
    REG_CLR   = 4'd7,
    REG_GSTAT = 4'd8,
    REG_GMASK = 4'd9
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] edge_hits(
    input logic [W-1:0] cur, input logic [W-1:0] prv,
    input logic [W-1:0] ren, input logic [W-1:0] fen);
    return (cur & ~prv & ren) | (~cur & prv & fen);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign hit_o = edge_hits(level_i, prev_q, rise_en_i, fall_en_i);
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  function automatic logic [W-1:0] sticky_next(
    input logic [W-1:0] cur, input logic [W-1:0] set, input logic [W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= sticky_next(stat_q, hit_i, clr_i);
  end

  assign stat_o = stat_q;

  // R6: a set bit that is not cleared stays set
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0));
  // R7: a cleared bit with no concurrent edge is zero afterwards
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_i) & ~$past(hit_i)) & stat_q) == '0));
  // R8: a detected edge always lands in status, even against a clear
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_i) & ~stat_q) == '0));
endmodule

// File: rtl/gpio_glb_irq.sv
module gpio_glb_irq #(
  parameter int unsigned GW      = 16,
  parameter int unsigned SRC_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_i,
  input  logic          wr_stat_i,
  input  logic          wr_mask_i,
  input  logic [GW-1:0] wdata_i,
  output logic [GW-1:0] stat_o,
  output logic [GW-1:0] mask_o,
  output logic [GW-1:0] irq_o
);
  logic [GW-1:0] mask_q;

  function automatic logic hold_set(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  for (genvar i = 0; i < GW; i++) begin : g_bit
    if (i == SRC_BIT) begin : g_src
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= hold_set(bit_q, src_i, wr_stat_i & wdata_i[i]);
      end
      assign stat_o[i] = bit_q;
    end else begin : g_none
      assign stat_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (wr_mask_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = stat_o & mask_q;

  // R9: an active source keeps the global bit set on the next cycle
  p_src_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_i |=> stat_o[SRC_BIT]);
  // R10: the line can only rise while its mask bit is set
  p_line_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[SRC_BIT]) |-> mask_o[SRC_BIT]);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned GW          = 16,
  parameter int unsigned GIRQ_BIT    = 15,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [W-1:0] WIRED_MASK = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_adr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ack,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [GW-1:0]     irq_line
);
  reg_sel_e      sel;
  logic          req, wr;
  logic          ack_q;
  logic [BUS_W-1:0] rdata_q, rd_mux;
  logic [W-1:0]  dir_q, dout_q, rise_q, fall_q, mask_q;
  logic [W-1:0]  sync_lvl, din_w, hit_w, clr_w, stat_w;
  logic          gpio_irq;
  logic [GW-1:0] glb_stat, glb_mask;

  assign sel = reg_sel_e'(bus_adr);
  assign req = bus_cyc & bus_stb & ~ack_q;
  assign wr  = req & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_DIR:  dir_q  <= bus_wdata[W-1:0];
        REG_DOUT: dout_q <= bus_wdata[W-1:0];
        REG_RISE: rise_q <= bus_wdata[W-1:0];
        REG_FALL: fall_q <= bus_wdata[W-1:0];
        REG_MASK: mask_q <= bus_wdata[W-1:0];
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(sync_lvl));

  assign din_w = sync_lvl & WIRED_MASK;

  gpio_edge_det #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(din_w),
    .rise_en_i(rise_q), .fall_en_i(fall_q), .hit_o(hit_w));

  assign clr_w = (wr && sel == REG_CLR) ? bus_wdata[W-1:0] : '0;

  gpio_status #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_w), .clr_i(clr_w), .stat_o(stat_w));

  assign gpio_irq = |(stat_w & mask_q);

  gpio_glb_irq #(.GW(GW), .SRC_BIT(GIRQ_BIT)) u_glb (
    .clk(clk), .rst_n(rst_n), .src_i(gpio_irq),
    .wr_stat_i(wr && sel == REG_GSTAT),
    .wr_mask_i(wr && sel == REG_GMASK),
    .wdata_i(bus_wdata[GW-1:0]),
    .stat_o(glb_stat), .mask_o(glb_mask), .irq_o(irq_line));

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_DIR:   rd_mux[W-1:0]  = dir_q;
      REG_DOUT:  rd_mux[W-1:0]  = dout_q;
      REG_DIN:   rd_mux[W-1:0]  = din_w;
      REG_RISE:  rd_mux[W-1:0]  = rise_q;
      REG_FALL:  rd_mux[W-1:0]  = fall_q;
      REG_MASK:  rd_mux[W-1:0]  = mask_q;
      REG_STAT:  rd_mux[W-1:0]  = stat_w;
      REG_GSTAT: rd_mux[GW-1:0] = glb_stat;
      REG_GMASK: rd_mux[GW-1:0] = glb_mask;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= req;
      if (req) rdata_q <= rd_mux;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign pin_oe    = dir_q;
  assign pin_out   = dout_q & dir_q;

  // R1: acknowledge is a single-cycle pulse
  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  // R1: every accepted request is acknowledged on the next cycle
  p_ack_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> bus_ack);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_adr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [15:0] irq_line;

  int errors = 0;
  int checks = 0;

  localparam logic [3:0] A_DIR = 0, A_DOUT = 1, A_DIN = 2, A_RISE = 3, A_FALL = 4,
                         A_MASK = 5, A_STAT = 6, A_CLR = 7, A_GSTAT = 8, A_GMASK = 9;
  localparam logic [31:0] WIRED = 32'h7FFF_FFFF;

  always #2 clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_line(irq_line));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata; ack = bus_ack;
    bus_cyc = 0; bus_stb = 0;
  endtask

  task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic ack;
    bus_read(a, d, ack);
    check(tag, d, exp);
  endtask

  task automatic settle(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (5) @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 pin_out", pin_out, 0);
    check("R11 pin_oe", pin_oe, 0);
    check("R11 irq_line", {16'h0, irq_line}, 0);
    read_chk("R11 status", A_STAT, 0);
    read_chk("R11 dir", A_DIR, 0);
  endtask

  task automatic t_output;
    logic [31:0] d;
    logic ack;
    bus_write(A_DIR, 32'hFFFF_FFFF);
    bus_write(A_DOUT, 32'h5555_5555);
    @(negedge clk);
    check("R2 pin_out 55", pin_out, 32'h5555_5555);
    check("R2 pin_oe", pin_oe, 32'hFFFF_FFFF);
    bus_read(A_DOUT, d, ack);
    check("R1 ack", {31'h0, ack}, 1);
    check("R1 dout readback", d, 32'h5555_5555);
    @(negedge clk);
    check("R1 ack single", {31'h0, bus_ack}, 0);
    bus_write(A_DIR, 32'h0000_FFFF);
    bus_write(A_DOUT, 32'hA5A5_A5A5);
    @(negedge clk);
    check("R2 partial dir", pin_out, 32'h0000_A5A5);
    bus_write(A_DIR, 32'h0);
  endtask

  task automatic t_input;
    settle(32'hFFFF_FFFF);
    read_chk("R3 unwired bit", A_DIN, WIRED);
    settle(32'h5A5A_5A5A);
    read_chk("R3 din 5A", A_DIN, 32'h5A5A_5A5A);
    settle(32'hA5A5_A5A5);
    read_chk("R3 din A5", A_DIN, 32'hA5A5_A5A5 & WIRED);
  endtask

  task automatic t_rise;
    bus_write(A_RISE, 32'hFFFF_FFFF);
    bus_write(A_FALL, 32'h0);
    settle(32'h0);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    read_chk("R7 cleared", A_STAT, 0);
    settle(32'h5555_5555);
    settle(32'h0);
    read_chk("R4 R6 rise sticky", A_STAT, 32'h5555_5555);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    settle(32'hFFFF_FFFF);
    read_chk("R3 unwired no status", A_STAT, WIRED);
  endtask

  task automatic t_fall;
    bus_write(A_RISE, 32'h0);
    bus_write(A_FALL, 32'hFFFF_FFFF);
    settle(32'hFFFF_FFFF);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    settle(32'hA5A5_A5A5);
    settle(32'hFFFF_FFFF);
    read_chk("R5 fall complement", A_STAT, ~32'hA5A5_A5A5 & WIRED);
  endtask

  task automatic t_partial;
    bus_write(A_FALL, 32'h0);
    bus_write(A_RISE, 32'h0000_FFFF);
    settle(32'h0);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    settle(32'hFFFF_FFFF);
    read_chk("R4 disabled bits", A_STAT, 32'h0000_FFFF);
    bus_write(A_CLR, 32'h0000_00F0);
    read_chk("R7 partial clear", A_STAT, 32'h0000_FF0F);
  endtask

  task automatic t_edge_wins;
    bus_write(A_RISE, 32'hFFFF_FFFF);
    settle(32'h0);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    settle(32'h1);
    read_chk("R4 stale bit", A_STAT, 32'h1);
    @(negedge clk);
    pin_in = 32'h3;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    bus_write(A_CLR, 32'h3);
    read_chk("R8 edge beats clear", A_STAT, 32'h2);
  endtask

  task automatic t_irq;
    settle(32'h0);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    bus_write(A_MASK, 32'h0);
    bus_write(A_GMASK, 32'h0);
    bus_write(A_GSTAT, 32'h8000);
    settle(32'h100);
    read_chk("R9 masked off", A_GSTAT, 0);
    bus_write(A_MASK, 32'h100);
    read_chk("R9 global set", A_GSTAT, 32'h8000);
    check("R10 gmask off", {16'h0, irq_line}, 0);
    bus_write(A_GMASK, 32'hFFFF);
    @(negedge clk);
    check("R10 line 15", {16'h0, irq_line}, 32'h8000);
    bus_write(A_GSTAT, 32'h8000);
    read_chk("R10 reasserted", A_GSTAT, 32'h8000);
    bus_write(A_CLR, 32'h100);
    bus_write(A_GSTAT, 32'h8000);
    read_chk("R10 global clear", A_GSTAT, 0);
    @(negedge clk);
    check("R10 line low", {16'h0, irq_line}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_rise();
    t_fall();
    t_partial();
    t_edge_wins();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule